// File: doc/BRIEF.md
# Vectorized Arithmetic-to-Boolean Mask Converter

This block takes a secret split into two arithmetic shares, where the secret equals the sum of the shares modulo 2^32. It returns the same secret as two Boolean shares, where the secret equals their XOR. Several 32-bit lanes are converted side by side. All lanes share one controller, so they finish in the same cycle.

Each arithmetic share is first given a fresh Boolean masking of its own. Share a0 becomes the pair (a0 ^ r0, r0) and share a1 becomes (a1 ^ r1, r1). These two pairs feed a two-share masked adder. The adder is bit-serial: it handles one bit position per cycle and uses two masked AND gates, each fed a fresh random bit. The carry is kept in shared form. After the last bit, one more random word re-masks the sum shares as they enter the output register. At no point is the secret recombined.

A pulse on `start_i` while the block is idle captures the shares and all randomness. `busy_o` stays high for W+1 cycles, after which `done_o` pulses for one cycle with the result on `b0_o` and `b1_o`.

Top module: `a2b_vec_conv`

## Requirements
- R1: For every lane, after `done_o`, `b0 ^ b1` equals `(a0 + a1) mod 2^32` of the inputs captured at start.
- R2: The recombined result does not depend on the randomness. Two conversions of the same shares with different random words give the same `b0 ^ b1`.
- R3: `done_o` rises exactly W+1 clock edges after the edge that samples `start_i` while idle (33 for W=32).
- R4: `busy_o` is high from the edge that accepts start until the edge that raises `done_o`, where it falls.
- R5: `done_o` is a single-cycle pulse.
- R6: A `start_i` pulse or a change of `a0_i`, `a1_i` or `rnd_i` while busy has no effect on the running conversion's latency or result.
- R7: `b0_o` and `b1_o` hold their values at all times except on the edge that raises `done_o`.
- R8: Lanes are independent. Lane l uses bits [l*W +: W] of `a0_i`, `a1_i`, `b0_o` and `b1_o`. Its randomness occupies bits [l*5W +: 5W] of `rnd_i`, split into r0 (lowest W), r1, refresh word, and 2W adder bits (highest).
- R9: After reset, `busy_o` and `done_o` are 0 and both share outputs are all zeros.
- R10: A carry out of bit 31 is dropped. For example, 0xFFFFFFFF + 1 gives 0, and 0x80000000 + 0x80000000 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a conversion when idle |
| a0_i | input | LANES*W | First arithmetic share per lane |
| a1_i | input | LANES*W | Second arithmetic share per lane |
| rnd_i | input | LANES*5*W | Fresh randomness per lane, captured at start |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when results are valid |
| b0_o | output | LANES*W | First Boolean share per lane |
| b1_o | output | LANES*W | Second Boolean share per lane |

## Verification
The controller assertions assume that `start_i` is a known value on every clock edge after reset. They also assume that a start raised while busy is meant to be ignored rather than queued. The hold check on the outputs assumes that nothing but the controller's final stage writes the output register.

The bench drives every input on the falling edge and holds `start_i` for exactly one cycle. Its only out-of-protocol event is a deliberate start pulse, together with new shares, in the middle of a run. Randomness is drawn fresh for each conversion, so the masking stays meaningful. Correctness, however, is judged only on the recombined value.

// File: rtl/a2b_pkg.sv
package a2b_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_OUT  = 2'd2
  } conv_state_e;

  // Random bits needed per lane: two reshare words, one refresh word,
  // and two bits per adder step.
  function automatic int rnd_per_lane(input int w);
    return 5 * w;
  endfunction

  // Two-share masked AND. Returns {z1, z0}, where z0 ^ z1 == (x0^x1) & (y0^y1).
  function automatic logic [1:0] dom_and(input logic x0, input logic x1,
                                         input logic y0, input logic y1,
                                         input logic r);
    logic z0, z1;
    z0 = (x0 & y0) ^ ((x0 & y1) ^ r);
    z1 = (x1 & y1) ^ ((x1 & y0) ^ r);
    return {z1, z0};
  endfunction

endpackage

// File: rtl/a2b_reshare.sv
module a2b_reshare #(
  parameter int W = 32
) (
  input  logic [W-1:0] a0_i,
  input  logic [W-1:0] a1_i,
  input  logic [W-1:0] r0_i,
  input  logic [W-1:0] r1_i,
  output logic [W-1:0] x0_o,
  output logic [W-1:0] x1_o,
  output logic [W-1:0] y0_o,
  output logic [W-1:0] y1_o
);
  // Each arithmetic share gets a Boolean masking of its own.
  assign x0_o = a0_i ^ r0_i;
  assign x1_o = r0_i;
  assign y0_o = a1_i ^ r1_i;
  assign y1_o = r1_i;
endmodule

// File: rtl/a2b_ctrl.sv
module a2b_ctrl
  import a2b_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic out_load_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  conv_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic          last_step;

  assign load_o     = start_i && (state_q == ST_IDLE);
  assign step_o     = (state_q == ST_RUN);
  assign last_step  = step_o && (cnt_q == CW'(W - 1));
  assign out_load_o = (state_q == ST_OUT);
  assign busy_o     = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= out_load_o;
      unique case (state_q)
        ST_IDLE: if (load_o) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_step) state_q <= ST_OUT;
        end
        ST_OUT:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r3_done_after_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(out_load_o));
  a_r4_busy_clear_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r6_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && start_i && !last_step) |=> (step_o && !load_o));
endmodule

// File: rtl/masked_serial_adder.sv
module masked_serial_adder
  import a2b_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   x0_i,
  input  logic [W-1:0]   x1_i,
  input  logic [W-1:0]   y0_i,
  input  logic [W-1:0]   y1_i,
  input  logic [2*W-1:0] rnd_i,
  output logic [W-1:0]   s0_o,
  output logic [W-1:0]   s1_o
);
  logic [W-1:0]   xs0_q, xs1_q, ys0_q, ys1_q;
  logic [2*W-1:0] rs_q;
  logic           c0_q, c1_q;
  logic           sum0, sum1;
  logic [1:0]     gen_sh, prop_sh;
  logic           p0, p1;

  // Sum bit and carry update for the current bit position, all in shares.
  always_comb begin
    p0      = xs0_q[0] ^ ys0_q[0];
    p1      = xs1_q[0] ^ ys1_q[0];
    sum0    = p0 ^ c0_q;
    sum1    = p1 ^ c1_q;
    gen_sh  = dom_and(xs0_q[0], xs1_q[0], ys0_q[0], ys1_q[0], rs_q[0]);
    prop_sh = dom_and(c0_q, c1_q, p0, p1, rs_q[1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xs0_q <= '0; xs1_q <= '0; ys0_q <= '0; ys1_q <= '0;
      rs_q  <= '0; c0_q  <= 1'b0; c1_q <= 1'b0;
      s0_o  <= '0; s1_o  <= '0;
    end else if (load_i) begin
      xs0_q <= x0_i; xs1_q <= x1_i; ys0_q <= y0_i; ys1_q <= y1_i;
      rs_q  <= rnd_i; c0_q  <= 1'b0; c1_q <= 1'b0;
      s0_o  <= '0; s1_o  <= '0;
    end else if (step_i) begin
      xs0_q <= xs0_q >> 1; xs1_q <= xs1_q >> 1;
      ys0_q <= ys0_q >> 1; ys1_q <= ys1_q >> 1;
      rs_q  <= rs_q >> 2;
      c0_q  <= gen_sh[0] ^ prop_sh[0];
      c1_q  <= gen_sh[1] ^ prop_sh[1];
      s0_o  <= {sum0, s0_o[W-1:1]};
      s1_o  <= {sum1, s1_o[W-1:1]};
    end
  end

  a_r1_carry_clear_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (c0_q == c1_q));
endmodule

// File: rtl/a2b_vec_conv.sv
module a2b_vec_conv
  import a2b_pkg::*;
#(
  parameter int LANES = 4,
  parameter int W     = 32
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 start_i,
  input  logic [LANES*W-1:0]                   a0_i,
  input  logic [LANES*W-1:0]                   a1_i,
  input  logic [LANES*rnd_per_lane(W)-1:0]     rnd_i,
  output logic                                 busy_o,
  output logic                                 done_o,
  output logic [LANES*W-1:0]                   b0_o,
  output logic [LANES*W-1:0]                   b1_o
);
  localparam int RW = rnd_per_lane(W);

  logic load, step, out_load;

  a2b_ctrl #(.W(W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .load_o     (load),
    .step_o     (step),
    .out_load_o (out_load),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [W-1:0] x0, x1, y0, y1, s0, s1;
    logic [W-1:0] refresh_q;

    a2b_reshare #(.W(W)) u_reshare (
      .a0_i (a0_i[l*W +: W]),
      .a1_i (a1_i[l*W +: W]),
      .r0_i (rnd_i[l*RW +: W]),
      .r1_i (rnd_i[l*RW + W +: W]),
      .x0_o (x0),
      .x1_o (x1),
      .y0_o (y0),
      .y1_o (y1)
    );

    masked_serial_adder #(.W(W)) u_add (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .step_i (step),
      .x0_i   (x0),
      .x1_i   (x1),
      .y0_i   (y0),
      .y1_i   (y1),
      .rnd_i  (rnd_i[l*RW + 3*W +: 2*W]),
      .s0_o   (s0),
      .s1_o   (s1)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        refresh_q       <= '0;
        b0_o[l*W +: W]  <= '0;
        b1_o[l*W +: W]  <= '0;
      end else begin
        if (load) refresh_q <= rnd_i[l*RW + 2*W +: W];
        if (out_load) begin
          b0_o[l*W +: W] <= s0 ^ refresh_q;
          b1_o[l*W +: W] <= s1 ^ refresh_q;
        end
      end
    end
  end

  a_r7_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_load |=> ($stable(b0_o) && $stable(b1_o)));
  a_r4_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !out_load) |=> busy_o);
endmodule

// File: tb/tb_a2b_vec_conv.sv
module tb_a2b_vec_conv;
  localparam int LANES = 4;
  localparam int W     = 32;
  localparam int RW    = 5 * W;
  localparam int AW    = LANES * W;
  localparam int RA    = LANES * RW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] a0 = '0, a1 = '0;
  logic [RA-1:0] rnd = '0;
  logic          busy, done;
  logic [AW-1:0] b0, b1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  a2b_vec_conv #(.LANES(LANES), .W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a0_i(a0), .a1_i(a1), .rnd_i(rnd),
    .busy_o(busy), .done_o(done), .b0_o(b0), .b1_o(b1)
  );

  // Reference sum built bit by bit with a ripple carry; the carry out of the top bit is lost.
  function automatic logic [W-1:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] s;
    logic c;
    c = 1'b0;
    for (int i = 0; i < W; i++) begin
      s[i] = x[i] ^ y[i] ^ c;
      c    = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [RA-1:0] rand_rnd();
    logic [RA-1:0] v;
    for (int i = 0; i < RA / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic run_conv(input logic [AW-1:0] a0v, input logic [AW-1:0] a1v,
                          input logic [RA-1:0] rv, input bit poke,
                          output int lat, output bit busy_ok);
    @(negedge clk);
    a0 = a0v; a1 = a1v; rnd = rv; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 0; busy_ok = 1'b1;
    while (!done && lat < 200) begin
      if (!busy) busy_ok = 1'b0;
      if (poke && lat == 5) begin
        start = 1'b1; a0 = ~a0v; a1 = a1v ^ {LANES{32'h5a5a_0001}}; rnd = ~rv;
      end else if (poke && lat == 6) begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    if (busy) busy_ok = 1'b0;
  endtask

  task automatic check_result(input logic [AW-1:0] a0v, input logic [AW-1:0] a1v,
                              input string req);
    for (int l = 0; l < LANES; l++) begin
      logic [W-1:0] exp, act;
      exp = ref_add(a0v[l*W +: W], a1v[l*W +: W]);
      act = b0[l*W +: W] ^ b1[l*W +: W];
      chk(act == exp, req, $sformatf("lane%0d b0^b1", l), act, exp);
    end
  endtask

  task automatic conv_and_check(input logic [AW-1:0] a0v, input logic [AW-1:0] a1v,
                                input string req);
    int lat;
    bit bok;
    run_conv(a0v, a1v, rand_rnd(), 1'b0, lat, bok);
    chk(lat == W + 1, "R3", "latency", W'(lat), W'(W + 1));
    chk(bok, "R4", "busy window", W'(bok), W'(1));
    check_result(a0v, a1v, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int lat;
    bit bok;
    logic [AW-1:0] ra0, ra1, hb0, hb1;
    logic [W-1:0] x_first;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    // R9: reset state
    chk(busy == 1'b0, "R9", "busy in reset", W'(busy), '0);
    chk(done == 1'b0, "R9", "done in reset", W'(done), '0);
    chk(b0 == '0 && b1 == '0, "R9", "shares in reset", b0[W-1:0] | b1[W-1:0], '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R9", "busy after reset", W'(busy), '0);

    // R10: wrap corners, different per lane (also R8 lane placement)
    conv_and_check({32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678},
                   {32'h8000_0000, 32'h0000_0000, 32'h0000_0001, 32'hEDCB_A988}, "R10");
    chk((b0[W +: W] ^ b1[W +: W]) == '0, "R10", "lane1 FFFFFFFF+1", b0[W +: W] ^ b1[W +: W], '0);

    // R5: done pulse lasts one cycle
    @(negedge clk);
    chk(done == 1'b0, "R5", "done after one cycle", W'(done), '0);

    // R8: all-ones in one lane only
    conv_and_check({32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0},
                   {32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0}, "R8");

    // R1: random shares
    for (int n = 0; n < 40; n++) begin
      for (int l = 0; l < LANES; l++) begin
        ra0[l*W +: W] = $urandom;
        ra1[l*W +: W] = $urandom;
      end
      conv_and_check(ra0, ra1, "R1");
    end

    // R2: same shares, different randomness
    for (int l = 0; l < LANES; l++) begin
      ra0[l*W +: W] = $urandom;
      ra1[l*W +: W] = $urandom;
    end
    run_conv(ra0, ra1, rand_rnd(), 1'b0, lat, bok);
    x_first = b0[W-1:0] ^ b1[W-1:0];
    run_conv(ra0, ra1, rand_rnd(), 1'b0, lat, bok);
    chk((b0[W-1:0] ^ b1[W-1:0]) == x_first, "R2", "recombined value vs rnd",
        b0[W-1:0] ^ b1[W-1:0], x_first);
    check_result(ra0, ra1, "R2");

    // R6: start and new inputs while busy
    for (int l = 0; l < LANES; l++) begin
      ra0[l*W +: W] = $urandom;
      ra1[l*W +: W] = $urandom;
    end
    run_conv(ra0, ra1, rand_rnd(), 1'b1, lat, bok);
    chk(lat == W + 1, "R6", "latency with mid-run start", W'(lat), W'(W + 1));
    check_result(ra0, ra1, "R6");
    @(negedge clk);
    chk(busy == 1'b0, "R6", "no second run queued", W'(busy), '0);

    // R7: outputs hold while inputs move without start
    hb0 = b0; hb1 = b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      a0 = {LANES{$urandom}}; a1 = ~a1; rnd = rand_rnd();
    end
    chk(b0 == hb0, "R7", "b0 held", b0[W-1:0], hb0[W-1:0]);
    chk(b1 == hb1, "R7", "b1 held", b1[W-1:0], hb1[W-1:0]);
    chk(done == 1'b0 && busy == 1'b0, "R7", "idle without start", W'({busy, done}), '0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule